// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Selective Status Update

This block is the data-path core of a small 8-bit processor. It takes two operand words, an operation code and the processor's current status flags. It produces the result word in the same cycle, without any register in the way. In parallel it computes six new status flags: half carry, sign, overflow, negative, zero and carry. These flags are loaded into an output register on the clock edge at which `exec_i` is high.

Each operation owns a fixed subset of the flags. Flags outside that subset are copied from `flags_i`, so a flag that an operation does not own passes through unchanged. The operations are add and subtract with or without carry-in, bitwise AND, OR and XOR, one's and two's complement, increment and decrement, logical and arithmetic right shift, left shift, rotates through carry, and half-word swap.

The surrounding core normally feeds `flags_o` back into `flags_i`. This lets a subtract-with-carry chain over several bytes and give a correct zero flag for the whole multi-byte value. The data width is a parameter and must be even. The half-carry boundary sits at the middle of the word, which is between bits 3 and 4 at the default width of 8.

Top module: `alu_status_core`

## Requirements
- R1: Flag encoding and register behaviour.
  - `flags_o` and `flags_i` carry H at bit 5, S at bit 4, V at bit 3, N at bit 2, Z at bit 1 and C at bit 0.
  - `flags_o` is zero after reset.
  - `flags_o` takes the newly computed flags at a rising clock edge with `exec_i` high, and holds its value when `exec_i` is low.
- R2: Opcode encoding and result timing.
  - `op_i` encodes: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 two's complement, 9 increment, 10 decrement, 11 logical shift right, 12 arithmetic shift right, 13 rotate right, 14 shift left, 15 rotate left, 16 swap.
  - `result_o` depends combinationally on `op_i`, `a_i`, `b_i` and the carry in `flags_i`. It does not depend on `exec_i` or the clock.
- R3: Add (0) and add with carry (1).
  - The result is a+b (plus C for opcode 1), modulo 2^W.
  - C is the carry out of the top bit, and H is the carry into bit W/2.
  - V is set on signed overflow.
  - N is the top result bit, Z is set when the result is zero, and S = N xor V.
- R4: Subtract (2) and subtract with carry (3).
  - The result is a-b (minus C for opcode 3).
  - C is set when a borrow out of the top bit occurs, and H is set when a borrow into bit W/2 occurs.
  - V is set on signed overflow.
  - N and S follow the rules of R3.
  - For opcode 2, Z is set when the result is zero.
- R5: For subtract with carry, the new Z is 1 only when the result is zero and the incoming Z is 1. Otherwise the new Z is 0.
- R6: AND, OR and XOR (4 to 6) update Z, N and S, and clear V. H and C keep their incoming values.
- R7: One's complement (7) gives the bitwise inverse of a. It sets C, clears V and updates Z, N and S. H keeps its incoming value.
- R8: Two's complement (8) gives 0-a. All six flags are set as for the subtraction 0-a, so C is set exactly when the result is nonzero.
- R9: Increment (9) and decrement (10) give a+1 and a-1 modulo 2^W. They update Z, N, V and S. V is set only when the increment or decrement crosses the signed limit. C and H keep their incoming values.
- R10: Right shifts and rotate.
  - Logical shift right (11) moves a zero into the top bit.
  - Arithmetic shift right (12) keeps the top bit.
  - Rotate right (13) moves the incoming C into the top bit.
  - For all three, C takes the old bit 0, V = N xor C after the operation, Z, N and S are updated, and H keeps its incoming value.
- R11: Left shift and rotate.
  - Shift left (14) moves a zero into bit 0, and rotate left (15) moves the incoming C into bit 0.
  - C takes the old top bit, and H takes old bit W/2-1.
  - V = N xor C, and Z, N and S are updated.
- R12: Swap (16) exchanges the upper and lower halves of a and leaves all six flags at their incoming values.
- R13: Codes 17 to 31 pass a through to the result and leave all flags at their incoming values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Load the computed flags at this edge |
| op_i | input | 5 | Operation code |
| a_i | input | W | First operand (destination operand) |
| b_i | input | W | Second operand |
| flags_i | input | 6 | Current status flags {H,S,V,N,Z,C} |
| result_o | output | W | Combinational result |
| flags_o | output | 6 | Registered status flags {H,S,V,N,Z,C} |

## Verification
The bench builds the unit with W = 4, so the half-carry boundary sits between bits 1 and 2. At this width, every pair of operands for the two-operand operations can be swept in full, and every operand for the one-operand operations, all against several incoming flag patterns. These patterns include carry set and clear, and zero set and clear. The sweeps therefore reach every signed-overflow edge, every borrow chain and both outcomes of the sticky zero rule. The same sweep covers the undefined opcodes, and separate steps check the hold behaviour with `exec_i` low.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

    localparam int unsigned OP_W   = 5;
    localparam int unsigned FLAG_W = 6;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_COM  = 5'd7,
        OP_NEG  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_LSR  = 5'd11,
        OP_ASR  = 5'd12,
        OP_ROR  = 5'd13,
        OP_LSL  = 5'd14,
        OP_ROL  = 5'd15,
        OP_SWAP = 5'd16
    } alu_op_e;

    // packed order gives H at bit 5 down to C at bit 0
    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOT = 2'd3
    } logic_kind_e;

    typedef enum logic [2:0] {
        SH_LSR  = 3'd0,
        SH_ASR  = 3'd1,
        SH_ROR  = 3'd2,
        SH_LSL  = 3'd3,
        SH_ROL  = 3'd4,
        SH_SWAP = 3'd5
    } shift_kind_e;

endpackage

// File: rtl/alu_addsub.sv
// Shared adder/subtractor: result, carry or borrow out of the top bit,
// carry or borrow across the middle of the word, signed overflow.
module alu_addsub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         half_o,
    output logic         ovf_o
);
    localparam int unsigned HALF = W / 2;

    logic [W:0]    wide_d;
    logic [HALF:0] low_d;

    always_comb begin
        if (sub_i) begin
            wide_d = {1'b0, lhs_i} - {1'b0, rhs_i} - {{W{1'b0}}, cin_i};
            low_d  = {1'b0, lhs_i[HALF-1:0]} - {1'b0, rhs_i[HALF-1:0]}
                   - {{HALF{1'b0}}, cin_i};
            ovf_o  = (lhs_i[W-1] != rhs_i[W-1]) && (wide_d[W-1] != lhs_i[W-1]);
        end else begin
            wide_d = {1'b0, lhs_i} + {1'b0, rhs_i} + {{W{1'b0}}, cin_i};
            low_d  = {1'b0, lhs_i[HALF-1:0]} + {1'b0, rhs_i[HALF-1:0]}
                   + {{HALF{1'b0}}, cin_i};
            ovf_o  = (lhs_i[W-1] == rhs_i[W-1]) && (wide_d[W-1] != lhs_i[W-1]);
        end
        res_o  = wide_d[W-1:0];
        cout_o = wide_d[W];
        half_o = low_d[HALF];
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_status_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_kind_e  kind_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (kind_i)
            LG_AND:  res_o = a_i & b_i;
            LG_OR:   res_o = a_i | b_i;
            LG_XOR:  res_o = a_i ^ b_i;
            default: res_o = ~a_i;
        endcase
    end

endmodule

// File: rtl/alu_shift.sv
// Single-place shifts, rotates through carry, and half-word swap.
module alu_shift
    import alu_status_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    input  shift_kind_e  kind_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    localparam int unsigned HALF = W / 2;

    logic top_in_d;
    logic bot_in_d;

    always_comb begin
        unique case (kind_i)
            SH_ASR:  top_in_d = a_i[W-1];
            SH_ROR:  top_in_d = cin_i;
            default: top_in_d = 1'b0;
        endcase
        bot_in_d = (kind_i == SH_ROL) ? cin_i : 1'b0;

        unique case (kind_i)
            SH_LSR, SH_ASR, SH_ROR: begin
                res_o  = {top_in_d, a_i[W-1:1]};
                cout_o = a_i[0];
            end
            SH_LSL, SH_ROL: begin
                res_o  = {a_i[W-2:0], bot_in_d};
                cout_o = a_i[W-1];
            end
            default: begin
                res_o  = {a_i[HALF-1:0], a_i[W-1:HALF]};
                cout_o = cin_i;
            end
        endcase
    end

endmodule

// File: rtl/alu_status_core.sv
module alu_status_core
    import alu_status_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  exec_i,
    input  logic [OP_W-1:0]       op_i,
    input  logic [W-1:0]          a_i,
    input  logic [W-1:0]          b_i,
    input  logic [FLAG_W-1:0]     flags_i,
    output logic [W-1:0]          result_o,
    output logic [FLAG_W-1:0]     flags_o
);
    localparam int unsigned HALF = W / 2;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // flag ownership masks, bit order H S V N Z C
    localparam logic [FLAG_W-1:0] M_ARITH = 6'b111111;
    localparam logic [FLAG_W-1:0] M_BITOP = 6'b011110;
    localparam logic [FLAG_W-1:0] M_RSHFT = 6'b011111;
    localparam logic [FLAG_W-1:0] M_NONE  = 6'b000000;

    alu_op_e     op;
    alu_flags_t  fin;
    alu_flags_t  flags_d, flags_q;

    logic [W-1:0] as_lhs, as_rhs, as_res;
    logic         as_cin, as_sub, as_cout, as_half, as_ovf;
    logic [W-1:0] lg_res;
    logic_kind_e  lg_kind;
    logic [W-1:0] sh_res;
    logic         sh_cout;
    shift_kind_e  sh_kind;

    assign op  = alu_op_e'(op_i);
    assign fin = alu_flags_t'(flags_i);

    // operand routing into the shared units
    always_comb begin
        as_lhs  = a_i;
        as_rhs  = b_i;
        as_cin  = 1'b0;
        as_sub  = 1'b0;
        lg_kind = LG_AND;
        sh_kind = SH_SWAP;
        unique case (op)
            OP_ADC: as_cin = fin.c;
            OP_SUB: as_sub = 1'b1;
            OP_SBC: begin as_sub = 1'b1; as_cin = fin.c; end
            OP_NEG: begin as_lhs = '0; as_rhs = a_i; as_sub = 1'b1; end
            OP_INC: as_rhs = ONE;
            OP_DEC: begin as_rhs = ONE; as_sub = 1'b1; end
            OP_OR:  lg_kind = LG_OR;
            OP_XOR: lg_kind = LG_XOR;
            OP_COM: lg_kind = LG_NOT;
            OP_LSR: sh_kind = SH_LSR;
            OP_ASR: sh_kind = SH_ASR;
            OP_ROR: sh_kind = SH_ROR;
            OP_LSL: sh_kind = SH_LSL;
            OP_ROL: sh_kind = SH_ROL;
            default: ;
        endcase
    end

    alu_addsub #(.W(W)) i_addsub (
        .lhs_i (as_lhs),
        .rhs_i (as_rhs),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .res_o (as_res),
        .cout_o(as_cout),
        .half_o(as_half),
        .ovf_o (as_ovf)
    );

    alu_logic #(.W(W)) i_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .kind_i(lg_kind),
        .res_o (lg_res)
    );

    alu_shift #(.W(W)) i_shift (
        .a_i   (a_i),
        .cin_i (fin.c),
        .kind_i(sh_kind),
        .res_o (sh_res),
        .cout_o(sh_cout)
    );

    // result, computed flags, ownership merge and next register value
    logic [W-1:0]      res_d;
    alu_flags_t        calc_d;
    logic [FLAG_W-1:0] mask_d;
    logic              shift_v_d;

    always_comb begin
        res_d     = a_i;
        calc_d    = fin;
        mask_d    = M_NONE;
        shift_v_d = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                res_d    = as_res;
                calc_d.h = as_half;
                calc_d.c = as_cout;
                calc_d.v = as_ovf;
                mask_d   = M_ARITH;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_d    = lg_res;
                calc_d.v = 1'b0;
                mask_d   = M_BITOP;
            end
            OP_COM: begin
                res_d    = lg_res;
                calc_d.v = 1'b0;
                calc_d.c = 1'b1;
                mask_d   = M_RSHFT;
            end
            OP_INC, OP_DEC: begin
                res_d    = as_res;
                calc_d.v = as_ovf;
                mask_d   = M_BITOP;
            end
            OP_LSR, OP_ASR, OP_ROR: begin
                res_d     = sh_res;
                calc_d.c  = sh_cout;
                shift_v_d = 1'b1;
                mask_d    = M_RSHFT;
            end
            OP_LSL, OP_ROL: begin
                res_d     = sh_res;
                calc_d.c  = sh_cout;
                calc_d.h  = a_i[HALF-1];
                shift_v_d = 1'b1;
                mask_d    = M_ARITH;
            end
            OP_SWAP: res_d = sh_res;
            default: ;
        endcase

        calc_d.n = res_d[W-1];
        calc_d.z = (res_d == '0) && ((op != OP_SBC) || fin.z);
        if (shift_v_d) begin
            calc_d.v = calc_d.n ^ calc_d.c;
        end
        calc_d.s = calc_d.n ^ calc_d.v;

        if (exec_i) begin
            flags_d = alu_flags_t'((mask_d & calc_d) | (~mask_d & flags_i));
        end else begin
            flags_d = flags_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign result_o = res_d;
    assign flags_o  = flags_q;

    // ---------------- assertions ----------------
    p_idle_holds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exec_i |=> $stable(flags_o));

    p_sbc_zero_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_i && op_i == OP_SBC && !flags_i[1]) |=> !flags_o[1]);

    p_bitop_clears_v_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR))
        |=> (!flags_o[3] && flags_o[0] == $past(flags_i[0])));

    p_incdec_keeps_c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_i && (op_i == OP_INC || op_i == OP_DEC))
        |=> (flags_o[0] == $past(flags_i[0]) && flags_o[5] == $past(flags_i[5])));

    p_rshift_v_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_i && (op_i == OP_LSR || op_i == OP_ASR || op_i == OP_ROR))
        |=> (flags_o[3] == (flags_o[2] ^ flags_o[0])));

    p_swap_keeps_flags_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_i && op_i == OP_SWAP) |=> (flags_o == $past(flags_i)));

    p_undef_keeps_flags_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_i && op_i > OP_SWAP) |=> (flags_o == $past(flags_i)));

endmodule

// File: tb/test_alu_status_core.sv
`timescale 1ns/1ps
module test_alu_status_core;
    localparam int WB   = 4;
    localparam int MOD  = 1 << WB;
    localparam int HM   = 1 << (WB / 2);
    localparam int MSB  = 1 << (WB - 1);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            exec;
    logic [4:0]      op;
    logic [WB-1:0]   a, b;
    logic [5:0]      fl_in;
    logic [WB-1:0]   result;
    logic [5:0]      fl_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    alu_status_core #(.W(WB)) i_alu_status_core (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .exec_i  (exec),
        .op_i    (op),
        .a_i     (a),
        .b_i     (b),
        .flags_i (fl_in),
        .result_o(result),
        .flags_o (fl_out)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (op %0d a %0h b %0h fin %0h)",
                     tag, what, act, exp, op, a, b, fl_in);
        end
    endtask

    function automatic int sg(input int x);
        return (x >= MSB) ? x - MOD : x;
    endfunction

    function automatic string tag_of(input int o);
        case (o)
            0, 1:        return "R3";
            2:           return "R4";
            3:           return "R5";
            4, 5, 6:     return "R6";
            7:           return "R7";
            8:           return "R8";
            9, 10:       return "R9";
            11, 12, 13:  return "R10";
            14, 15:      return "R11";
            16:          return "R12";
            default:     return "R13";
        endcase
    endfunction

    // reference model from the requirement text
    task automatic model(input int o, input int x, input int y, input int f,
                         output int r, output int fo);
        int h, s, v, n, z, c, ci, lhs, rhs, t, st;
        bit arith, sub, own_h, own_c, own_v, own_nz;
        h = (f >> 5) & 1; s = (f >> 4) & 1; v = (f >> 3) & 1;
        n = (f >> 2) & 1; z = (f >> 1) & 1; c = f & 1;
        r = x; arith = 0; sub = 0; ci = 0; lhs = x; rhs = y;
        own_h = 0; own_c = 0; own_v = 0; own_nz = 1;
        case (o)
            0: arith = 1;
            1: begin arith = 1; ci = c; end
            2: begin arith = 1; sub = 1; end
            3: begin arith = 1; sub = 1; ci = c; end
            8: begin arith = 1; sub = 1; lhs = 0; rhs = x; end
            9: begin arith = 1; rhs = 1; end
            10: begin arith = 1; sub = 1; rhs = 1; end
            default: ;
        endcase
        if (arith) begin
            if (sub) begin
                t  = lhs - rhs - ci;
                st = sg(lhs) - sg(rhs) - ci;
                if (o != 9 && o != 10) begin
                    c = (t < 0);
                    h = ((lhs % HM) - (rhs % HM) - ci) < 0;
                end
            end else begin
                t  = lhs + rhs + ci;
                st = sg(lhs) + sg(rhs) + ci;
                if (o != 9 && o != 10) begin
                    c = (t >= MOD);
                    h = ((lhs % HM) + (rhs % HM) + ci) >= HM;
                end
            end
            r = (t + 2 * MOD) % MOD;
            v = (st > MSB - 1) || (st < -MSB);
        end
        case (o)
            4: begin r = x & y; v = 0; end
            5: begin r = x | y; v = 0; end
            6: begin r = x ^ y; v = 0; end
            7: begin r = (MOD - 1) - x; v = 0; c = 1; end
            11: begin r = x / 2; c = x % 2; end
            12: begin r = x / 2 + (x & MSB); c = x % 2; end
            13: begin r = x / 2 + c * MSB; c = x % 2; end
            14: begin r = (x * 2) % MOD; h = (x / (HM / 2)) % 2; c = x / MSB; end
            15: begin r = (x * 2) % MOD + c; h = (x / (HM / 2)) % 2; c = x / MSB; end
            16: begin r = (x % HM) * HM + x / HM; own_nz = 0; end
            default: if (o > 16) own_nz = 0;
        endcase
        if (own_nz) begin
            n = (r >= MSB);
            z = (o == 3) ? ((r == 0) && z) : (r == 0);
            if (o >= 11 && o <= 15) v = n ^ c;
            s = n ^ v;
        end
        fo = (h << 5) | (s << 4) | (v << 3) | (n << 2) | (z << 1) | c;
    endtask

    task automatic run_vec(input int o, input int x, input int y, input int f);
        int er, ef;
        @(negedge clk);
        op = 5'(o); a = WB'(x); b = WB'(y); fl_in = 6'(f); exec = 1'b1;
        model(o, x, y, f, er, ef);
        #1;
        check(tag_of(o), int'(result), er, "result");
        @(negedge clk);
        check(tag_of(o), int'(fl_out), ef, "flags");
        exec = 1'b0;
    endtask

    int fl_set [5] = '{6'h00, 6'h3F, 6'h01, 6'h02, 6'h25};
    int op_set [19] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,16,17,31};

    initial begin
        int keep, er, ef;
        rst_n = 1'b0; exec = 1'b0; op = '0; a = '0; b = '0; fl_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(fl_out), 0, "reset flags");
        rst_n = 1'b1;

        foreach (fl_set[fi]) begin
            foreach (op_set[oi]) begin
                for (int x = 0; x < MOD; x++) begin
                    if (op_set[oi] <= 6) begin
                        for (int y = 0; y < MOD; y++) run_vec(op_set[oi], x, y, fl_set[fi]);
                    end else begin
                        run_vec(op_set[oi], x, 5, fl_set[fi]);
                    end
                end
            end
        end

        // R1 hold with exec low, R2 combinational result with no edge needed
        run_vec(2, 3, 9, 6'h00);
        keep = int'(fl_out);
        @(negedge clk);
        exec = 1'b0; op = 5'd0; a = 4'd7; b = 4'd9; fl_in = 6'h3F;
        #1;
        model(0, 7, 9, 6'h3F, er, ef);
        check("R2", int'(result), er, "comb result");
        repeat (3) @(negedge clk);
        check("R1", int'(fl_out), keep, "hold with exec low");
        op = 5'd16; a = 4'hA;
        #1;
        check("R2", int'(result), 4'hA, "swap result without edge");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule